// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Atomic Set and Clear

This block is one general purpose I/O port of `PIN_W` pins sitting behind a simple word-addressed register bus. Software picks, pin by pin, whether the pad is run by the port's own direction and output-data registers or by one of three peripheral functions. It changes output bits without a read-modify-write sequence, through a set register and a clear register. Pad inputs pass through a two-flop synchroniser. The synchronised levels can be read back and are also handed to the peripherals.

Six registers sit at word offsets 0 to 5: pin function select (0), direction (1), output data (2), set (3), clear (4) and drive strength (5). A read strobe captures the addressed register into `rdata` on the clock edge, so the value is valid from the cycle after `rd_en`. A write takes effect on the edge where `wr_en` is high. Only one register can be written per cycle, so a set and a clear never collide. Pins that `IMPL_MASK` marks as absent are treated as reserved.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the direction and drive registers read 0, the function-select register reads 0 (every pin GPIO), the output data register reads `IMPL_MASK`, and every pad output-enable is 0.
- R2: For a pin in GPIO mode, `pad_oe` equals its direction bit (1 = output, 0 = input) and `pad_o` equals its output data bit.
- R3: The output data register (offset 2) and the direction register (offset 1) are written directly and read back their stored value. Bits outside `IMPL_MASK` always read 0 and ignore writes. Output data changes only on a write.
- R4: Writing offset 3 sets every output data bit where the written bit is 1. Bits written 0 keep their value.
- R5: Reading offset 3 returns the pad input levels, masked by `IMPL_MASK`, after a two-flop synchroniser. A level held for two clock edges is visible there and on `pin_sync`.
- R6: Writing offset 4 clears every output data bit where the written bit is 0. Bits written 1 keep their value. A read of offset 4 always returns 0.
- R7: The function field of pin i is bits [2i+1:2i] of offset 0. 00 selects GPIO, 01 selects alternate function 1, 10 selects alternate function 2, and 11 selects the primary function. The selected function's output and enable drive the pad.
- R8: Offset 5 holds `DRV_GROUPS` bits. Bit g drives `drive_hi` of the g-th group of `PIN_W/DRV_GROUPS` consecutive pins. Higher bits read 0.
- R9: Read data appears on `rdata` in the cycle after `rd_en`. Offsets 6 and 7 read 0 and writes to them change nothing.
- R10: A reserved pin always has `pad_o` = 0 and `pad_oe` = 0, and its function field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | 2*PIN_W | Write data |
| rdata | output | 2*PIN_W | Read data, registered |
| pad_in | input | PIN_W | Raw pad input levels |
| pad_o | output | PIN_W | Pad output value |
| pad_oe | output | PIN_W | Pad output enable |
| pin_sync | output | PIN_W | Synchronised pad levels for peripherals |
| drive_hi | output | PIN_W | Per-pin high drive strength request |
| prim_o | input | PIN_W | Primary function output |
| prim_oe | input | PIN_W | Primary function enable |
| alt1_o | input | PIN_W | Alternate function 1 output |
| alt1_oe | input | PIN_W | Alternate function 1 enable |
| alt2_o | input | PIN_W | Alternate function 2 output |
| alt2_oe | input | PIN_W | Alternate function 2 enable |

## Verification
The bench builds the port with `PIN_W`=8, `IMPL_MASK`=8'h7F and `DRV_GROUPS`=2. The reserved top pin therefore exercises masking in every register, in the function field and on the pad, and each drive bit covers a four-pin group. The two unmapped offsets fit in the three-bit address, so writes to them and reads of them are reachable in both the random and the directed traffic.

// File: rtl/gpio_pc_pkg.sv
package gpio_pc_pkg;

  // register word offsets
  localparam int OFS_FUNC = 0;
  localparam int OFS_DIR  = 1;
  localparam int OFS_OUT  = 2;
  localparam int OFS_SET  = 3;
  localparam int OFS_CLR  = 4;
  localparam int OFS_DRV  = 5;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_ALT1 = 2'b01,
    FN_ALT2 = 2'b10,
    FN_PRIM = 2'b11
  } fn_sel_e;

endpackage

// File: rtl/gpio_pc_sync.sv
module gpio_pc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/gpio_pc_regs.sv
module gpio_pc_regs
  import gpio_pc_pkg::*;
#(
  parameter int               PIN_W      = 8,
  parameter logic [PIN_W-1:0] IMPL_MASK  = '1,
  parameter int               DRV_GROUPS = 2,
  parameter int               ADDR_W     = 3,
  localparam int              BUS_W      = 2 * PIN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  input  logic [PIN_W-1:0]      pin_sync,
  output logic [BUS_W-1:0]      rdata,
  output logic [BUS_W-1:0]      func_q,
  output logic [PIN_W-1:0]      dir_q,
  output logic [PIN_W-1:0]      out_q,
  output logic [DRV_GROUPS-1:0] drv_q
);
  logic [BUS_W-1:0] fld_mask;
  logic [PIN_W-1:0] wd_pins;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  for (genvar i = 0; i < PIN_W; i++) begin : g_fmask
    assign fld_mask[2*i +: 2] = {2{IMPL_MASK[i]}};
  end

  assign wd_pins = wdata[PIN_W-1:0];

  // register writes; one register per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      dir_q  <= '0;
      out_q  <= IMPL_MASK;
      drv_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_FUNC)) func_q <= wdata & fld_mask;
      if (addr == ADDR_W'(OFS_DIR))  dir_q  <= wd_pins & IMPL_MASK;
      if (addr == ADDR_W'(OFS_OUT))  out_q  <= wd_pins & IMPL_MASK;
      if (addr == ADDR_W'(OFS_SET))  out_q  <= (out_q | wd_pins) & IMPL_MASK;
      if (addr == ADDR_W'(OFS_CLR))  out_q  <= out_q & wd_pins;
      if (addr == ADDR_W'(OFS_DRV))  drv_q  <= wdata[DRV_GROUPS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_FUNC)) rd_mux = func_q;
    if (addr == ADDR_W'(OFS_DIR))  rd_mux = BUS_W'(dir_q);
    if (addr == ADDR_W'(OFS_OUT))  rd_mux = BUS_W'(out_q);
    if (addr == ADDR_W'(OFS_SET))  rd_mux = BUS_W'(pin_sync & IMPL_MASK);
    if (addr == ADDR_W'(OFS_DRV))  rd_mux = BUS_W'(drv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_SET)) |=>
      ((out_q & $past(wd_pins) & IMPL_MASK) == ($past(wd_pins) & IMPL_MASK))); // R4
  AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_SET)) |=>
      ((out_q & ~$past(wd_pins)) == ($past(out_q) & ~$past(wd_pins)))); // R4
  AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CLR)) |=>
      ((out_q & ~$past(wd_pins)) == '0)); // R6
  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CLR)) |=>
      ((out_q & $past(wd_pins)) == ($past(out_q) & $past(wd_pins)))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_q)); // R3
  AST_RSVD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q & ~IMPL_MASK) == '0) && ((dir_q & ~IMPL_MASK) == '0)); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: rtl/gpio_pc_pinmux.sv
module gpio_pc_pinmux
  import gpio_pc_pkg::*;
#(
  parameter int               PIN_W      = 8,
  parameter logic [PIN_W-1:0] IMPL_MASK  = '1,
  parameter int               DRV_GROUPS = 2,
  localparam int              GRP_PINS   = PIN_W / DRV_GROUPS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*PIN_W-1:0]    func_q,
  input  logic [PIN_W-1:0]      dir_q,
  input  logic [PIN_W-1:0]      out_q,
  input  logic [DRV_GROUPS-1:0] drv_q,
  input  logic [PIN_W-1:0]      prim_o,
  input  logic [PIN_W-1:0]      prim_oe,
  input  logic [PIN_W-1:0]      alt1_o,
  input  logic [PIN_W-1:0]      alt1_oe,
  input  logic [PIN_W-1:0]      alt2_o,
  input  logic [PIN_W-1:0]      alt2_oe,
  output logic [PIN_W-1:0]      pad_o,
  output logic [PIN_W-1:0]      pad_oe,
  output logic [PIN_W-1:0]      drive_hi
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    if (IMPL_MASK[i]) begin : g_live
      fn_sel_e sel;
      assign sel = fn_sel_e'(func_q[2*i +: 2]);
      always_comb begin
        unique case (sel)
          FN_GPIO: begin pad_o[i] = out_q[i];  pad_oe[i] = dir_q[i];   end
          FN_ALT1: begin pad_o[i] = alt1_o[i]; pad_oe[i] = alt1_oe[i]; end
          FN_ALT2: begin pad_o[i] = alt2_o[i]; pad_oe[i] = alt2_oe[i]; end
          default: begin pad_o[i] = prim_o[i]; pad_oe[i] = prim_oe[i]; end
        endcase
      end
    end else begin : g_rsvd
      assign pad_o[i]  = 1'b0;
      assign pad_oe[i] = 1'b0;
    end
    assign drive_hi[i] = drv_q[i / GRP_PINS];
  end

  AST_RSVD_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~IMPL_MASK) == '0) && ((pad_o & ~IMPL_MASK) == '0)); // R10
  AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q == '0) |-> ((pad_oe == dir_q) && (pad_o == out_q))); // R2
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_pc_pkg::*;
#(
  parameter int               PIN_W      = 8,
  parameter logic [PIN_W-1:0] IMPL_MASK  = '1,
  parameter int               DRV_GROUPS = 2,
  parameter int               ADDR_W     = 3,
  localparam int              BUS_W      = 2 * PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_o,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pin_sync,
  output logic [PIN_W-1:0]  drive_hi,
  input  logic [PIN_W-1:0]  prim_o,
  input  logic [PIN_W-1:0]  prim_oe,
  input  logic [PIN_W-1:0]  alt1_o,
  input  logic [PIN_W-1:0]  alt1_oe,
  input  logic [PIN_W-1:0]  alt2_o,
  input  logic [PIN_W-1:0]  alt2_oe
);
  logic [BUS_W-1:0]      func_q;
  logic [PIN_W-1:0]      dir_q;
  logic [PIN_W-1:0]      out_q;
  logic [DRV_GROUPS-1:0] drv_q;

  gpio_pc_sync #(.W(PIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_pc_regs #(
    .PIN_W(PIN_W), .IMPL_MASK(IMPL_MASK), .DRV_GROUPS(DRV_GROUPS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_sync(pin_sync),
    .rdata   (rdata),
    .func_q  (func_q),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .drv_q   (drv_q)
  );

  gpio_pc_pinmux #(
    .PIN_W(PIN_W), .IMPL_MASK(IMPL_MASK), .DRV_GROUPS(DRV_GROUPS)
  ) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .func_q  (func_q),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .drv_q   (drv_q),
    .prim_o  (prim_o),
    .prim_oe (prim_oe),
    .alt1_o  (alt1_o),
    .alt1_oe (alt1_oe),
    .alt2_o  (alt2_o),
    .alt2_oe (alt2_oe),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe),
    .drive_hi(drive_hi)
  );

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_CLR)) |=> (rdata == '0)); // R6
  AST_SET_READS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_SET)) |=>
      (rdata == BUS_W'($past(pin_sync) & IMPL_MASK))); // R5
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > ADDR_W'(OFS_DRV)) |=> (rdata == '0)); // R9
endmodule

// File: tb/tb_gpio_setclr_port.sv
module tb_gpio_setclr_port;
  localparam int PIN_W = 8;
  localparam logic [PIN_W-1:0] MASK = 8'h7F;
  localparam int DRVG = 2;
  localparam int AW = 3;
  localparam int BW = 2 * PIN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic [PIN_W-1:0] pad_in = '0, pad_o, pad_oe, pin_sync, drive_hi;
  logic [PIN_W-1:0] prim_o = '0, prim_oe = '0, alt1_o = '0, alt1_oe = '0, alt2_o = '0, alt2_oe = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [BW-1:0]    m_func;
  logic [PIN_W-1:0] m_dir, m_out;
  logic [DRVG-1:0]  m_drv;

  always #5 clk = ~clk;

  gpio_setclr_port #(.PIN_W(PIN_W), .IMPL_MASK(MASK), .DRV_GROUPS(DRVG), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_o(pad_o), .pad_oe(pad_oe), .pin_sync(pin_sync),
    .drive_hi(drive_hi), .prim_o(prim_o), .prim_oe(prim_oe), .alt1_o(alt1_o),
    .alt1_oe(alt1_oe), .alt2_o(alt2_o), .alt2_oe(alt2_oe));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] fmask();
    logic [BW-1:0] m;
    for (int i = 0; i < PIN_W; i++) m[2*i +: 2] = {2{MASK[i]}};
    return m;
  endfunction

  function automatic void model_wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    case (a)
      3'd0: m_func = d & fmask();
      3'd1: m_dir  = d[PIN_W-1:0] & MASK;
      3'd2: m_out  = d[PIN_W-1:0] & MASK;
      3'd3: m_out  = (m_out | d[PIN_W-1:0]) & MASK;
      3'd4: m_out  = m_out & d[PIN_W-1:0];
      3'd5: m_drv  = d[DRVG-1:0];
      default: ;
    endcase
  endfunction

  function automatic logic [BW-1:0] model_rd(input logic [AW-1:0] a);
    case (a)
      3'd0: return m_func;
      3'd1: return BW'(m_dir);
      3'd2: return BW'(m_out);
      3'd3: return BW'(pad_in & MASK);
      3'd5: return BW'(m_drv);
      default: return '0;
    endcase
  endfunction

  function automatic logic [2*PIN_W-1:0] model_pads();
    logic [PIN_W-1:0] o, oe;
    for (int i = 0; i < PIN_W; i++) begin
      if (!MASK[i]) begin o[i] = 0; oe[i] = 0; end
      else case (m_func[2*i +: 2])
        2'b00: begin o[i] = m_out[i];  oe[i] = m_dir[i];   end
        2'b01: begin o[i] = alt1_o[i]; oe[i] = alt1_oe[i]; end
        2'b10: begin o[i] = alt2_o[i]; oe[i] = alt2_oe[i]; end
        default: begin o[i] = prim_o[i]; oe[i] = prim_oe[i]; end
      endcase
    end
    return {oe, o};
  endfunction

  function automatic logic [PIN_W-1:0] model_drv();
    logic [PIN_W-1:0] d;
    for (int i = 0; i < PIN_W; i++) d[i] = m_drv[i / (PIN_W / DRVG)];
    return d;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [BW-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    logic [BW-1:0] d;
    logic [BW-1:0] e;
    e = model_rd(a);
    rd(a, d);
    chk(32'(d), 32'(e), tag);
  endtask

  task automatic pads_chk(input string tag);
    #1;
    chk(32'({pad_oe, pad_o}), 32'(model_pads()), tag);
    chk(32'(drive_hi), 32'(model_drv()), {tag, " drive R8"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [BW-1:0] d;
    void'($urandom(32'h5EED));
    m_func = '0; m_dir = '0; m_out = MASK; m_drv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) if (a != 3) rd_chk(AW'(a), "R1 reset read");
    pads_chk("R1 reset pads");
    chk(32'(pad_oe), 0, "R1 all inputs");

    // R9 unmapped offsets
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    rd_chk(3'd6, "R9 offset 6 reads 0");
    rd_chk(3'd7, "R9 offset 7 reads 0");
    rd_chk(3'd2, "R9 unmapped write leaves out");

    // R3 direct write, reserved bit
    wr(3'd2, 16'h00FF);
    rd_chk(3'd2, "R3 reserved bit reads 0");
    chk(32'(m_out), 32'h7F, "R3 model sanity");
    wr(3'd1, 16'h00A5); rd_chk(3'd1, "R3 direction readback");
    pads_chk("R2 gpio pads");

    // R4 set with zeros is a no-op, ones set
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000); rd_chk(3'd2, "R4 set zero no effect");
    wr(3'd3, 16'h0012); rd_chk(3'd2, "R4 set ones");
    chk(32'(m_out), 32'h12, "R4 expected value");

    // R6 clear
    wr(3'd2, 16'h007F);
    wr(3'd4, 16'h00FF); rd_chk(3'd2, "R6 clear ones no effect");
    wr(3'd4, 16'h00F0); rd_chk(3'd2, "R6 clear zeros");
    rd_chk(3'd4, "R6 clear reads zero");

    // R5 synchroniser
    pad_in = 8'hC3;
    @(negedge clk); #1 chk(32'(pin_sync), 0, "R5 one edge not yet visible");
    @(negedge clk); #1 chk(32'(pin_sync), 32'hC3, "R5 two edges visible");
    rd_chk(3'd3, "R5 set register reads pins");

    // R7 each function code, R10 reserved field
    prim_o = 8'hFF; prim_oe = 8'hFF; alt1_o = 8'h0F; alt1_oe = 8'hF0; alt2_o = 8'h33; alt2_oe = 8'hCC;
    wr(3'd0, 16'hFFFF); rd_chk(3'd0, "R10 reserved field reads 0");
    pads_chk("R7 primary");
    wr(3'd0, 16'h5555); pads_chk("R7 alt1");
    wr(3'd0, 16'hAAAA); pads_chk("R7 alt2");
    wr(3'd0, 16'h1B1B); pads_chk("R7 mixed codes");
    chk(32'(pad_oe[7]), 0, "R10 reserved pad enable");

    // R8 drive groups
    wr(3'd5, 16'hFFFE); rd_chk(3'd5, "R8 drive readback");
    pads_chk("R8 group1 only");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      pad_in = PIN_W'($urandom);
      prim_o = PIN_W'($urandom); prim_oe = PIN_W'($urandom);
      alt1_o = PIN_W'($urandom); alt1_oe = PIN_W'($urandom);
      alt2_o = PIN_W'($urandom); alt2_oe = PIN_W'($urandom);
      a = AW'($urandom);
      wr(a, BW'($urandom));
      pads_chk("R2 R7 random pads");
      rd_chk(AW'($urandom % 8), "R3 R4 R5 R6 R9 random read");
    end

    rd(3'd2, d);
    chk(32'(d & ~BW'(MASK)), 0, "R3 final reserved");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule